// File: doc/BRIEF.md
# Set-Associative Instruction Cache with Control Bits

This block is the first-level instruction store of a processor fetch path. It holds 32 KB of instructions in lines of 32 bytes (eight 32-bit words), organised as 256 sets of four ways and indexed by the physical fetch address. A fetch that hits returns up to four consecutive instructions, starting at the addressed word, in the cycle after the request. A fetch that misses raises a line request toward memory, stalls further fetches, and returns the same group of instructions once the memory side delivers the whole line in a single refill beat.

Four control inputs shape its behaviour. Disable sends every fetch to memory and leaves the stored lines alone. Lock keeps serving hits but stops misses from taking a line. Flash invalidate empties the whole cache in one cycle. The fetch-coherency mode bit, together with the translation-enable bit and the page coherency bit that come with each fetch, decides the global attribute attached to each line request.

Top module: `icache_top`

## Requirements
- R1: After reset no response and no line request is raised, fetch_ready is 1 and every line is invalid, so the first fetch to any address misses.
- R2: A fetch that hits raises resp_valid in the next cycle with no line request. resp_words carries the addressed word in bits [31:0] and the following words of the same line above it. resp_count = min(4, 8 - w), where w = fetch_addr[4:2], and slots at or beyond the end of the line are zero.
- R3: A fetch that misses raises miss_req_valid for one cycle in the next cycle, with miss_req_addr equal to fetch_addr with bits [4:0] cleared. The cycle after refill_valid is seen, resp_valid carries the words selected as in R2 from refill_line, where word k of the line is refill_line[32k+31:32k].
- R4: Bits [12:5] of the address select the set and bits [31:13] form the tag. Lines with the same set bits and different tags compete for the four ways of one set, and lines in different sets never displace each other.
- R5: An allocating refill writes the lowest-numbered invalid way of its set. If all four ways are valid it writes the way named by a 3-bit tree per set: if t0 = 0 the victim is way {0,t1}, otherwise way {1,t2}. A hit or a fill of way w sets t0 = ~w[1], and sets t1 = ~w[0] if w[1] = 0 or t2 = ~w[0] if w[1] = 1. Flash invalidate leaves the trees unchanged.
- R6: miss_req_global is 0 when ctl_fetch_coh is 0. When ctl_fetch_coh is 1 it equals fetch_page_coh if fetch_xlat_on is 1, and it is 1 if fetch_xlat_on is 0.
- R7: While ctl_disable is 1 every fetch is handled as a miss with miss_req_alloc = 0, and the stored lines are not changed, so a line present before disabling still hits once ctl_disable returns to 0.
- R8: While ctl_lock is 1 hits are served normally, and misses have miss_req_alloc = 0 and write no line, so a missed line misses again and no valid line is replaced.
- R9: A cycle with ctl_flash_inv = 1 makes every line invalid from the next cycle on. A refill arriving in that same cycle still answers the fetch but writes no line.
- R10: fetch_ready is 0 from the cycle after a miss is accepted up to and including the refill cycle, and is 1 again in the cycle after the refill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| fetch_valid | input | 1 | Fetch request present |
| fetch_addr | input | 32 | Physical byte address of the fetch, word aligned |
| fetch_xlat_on | input | 1 | Instruction translation enabled for this fetch |
| fetch_page_coh | input | 1 | Coherency attribute of the page or block |
| fetch_ready | output | 1 | Fetch can be accepted this cycle |
| resp_valid | output | 1 | Instruction group valid |
| resp_words | output | 128 | Up to four instructions, addressed word lowest |
| resp_count | output | 3 | Number of valid instructions in resp_words |
| miss_req_valid | output | 1 | One-cycle line request toward memory |
| miss_req_addr | output | 32 | Line-aligned address of the request |
| miss_req_global | output | 1 | Global coherency attribute of the request |
| miss_req_alloc | output | 1 | The returned line will be stored |
| refill_valid | input | 1 | Whole line delivered this cycle |
| refill_line | input | 256 | Line data, word k in bits [32k+31:32k] |
| ctl_disable | input | 1 | Cache disabled |
| ctl_flash_inv | input | 1 | Invalidate every line |
| ctl_lock | input | 1 | Cache contents locked |
| ctl_fetch_coh | input | 1 | Fetch coherency mode |

## Verification
The properties take for granted that fetch addresses are word aligned, that refill_valid is raised only while a line request is outstanding and only once per request, and that ctl_flash_inv is not raised in the same cycle as a fetch lookup; one property states the alignment assumption outright. The stimulus keeps within this: addresses are built from a tag, a set and a word offset with the two byte bits zero, the memory model answers each request exactly once after zero to three idle cycles, and flash pulses are issued only between fetches or on the refill beat itself. The random part draws tags and sets from a small pool so that sets overflow often and the replacement tree, lock and disable paths are exercised against the bench model.

// File: rtl/icache_pkg.sv
package icache_pkg;

  localparam int ADDR_W      = 32;
  localparam int CACHE_BYTES = 32768;
  localparam int WAYS        = 4;
  localparam int LINE_BYTES  = 32;
  localparam int WORD_W      = 32;
  localparam int FETCH_WORDS = 4;

  localparam int WORD_BYTES = WORD_W / 8;
  localparam int LINE_WORDS = LINE_BYTES / WORD_BYTES;
  localparam int SETS       = CACHE_BYTES / (LINE_BYTES * WAYS);
  localparam int OFF_W      = $clog2(LINE_BYTES);
  localparam int WB_W       = $clog2(WORD_BYTES);
  localparam int WOFF_W     = $clog2(LINE_WORDS);
  localparam int IDX_W      = $clog2(SETS);
  localparam int TAG_W      = ADDR_W - OFF_W - IDX_W;
  localparam int LADDR_W    = ADDR_W - OFF_W;
  localparam int WAY_W      = $clog2(WAYS);
  localparam int PLRU_W     = WAYS - 1;
  localparam int LINE_W     = LINE_BYTES * 8;
  localparam int FETCH_W    = FETCH_WORDS * WORD_W;
  localparam int CNT_W      = $clog2(FETCH_WORDS + 1);

  typedef logic [TAG_W-1:0]   tag_t;
  typedef logic [IDX_W-1:0]   idx_t;
  typedef logic [WAY_W-1:0]   way_t;
  typedef logic [PLRU_W-1:0]  plru_t;
  typedef logic [LINE_W-1:0]  line_t;
  typedef logic [FETCH_W-1:0] fetch_t;
  typedef logic [WOFF_W-1:0]  woff_t;
  typedef logic [CNT_W-1:0]   cnt_t;
  typedef logic [LADDR_W-1:0] laddr_t;

  // Global attribute of a fetch miss.
  function automatic logic glob_attr(input logic mode, input logic xlat, input logic coh);
    return mode & (~xlat | coh);
  endfunction

  // Number of instructions delivered for a given word offset.
  function automatic cnt_t fetch_count(input woff_t woff);
    int rem;
    rem = LINE_WORDS - int'(woff);
    if (rem > FETCH_WORDS) return cnt_t'(FETCH_WORDS);
    return cnt_t'(rem);
  endfunction

  // Words from the addressed one upward, zero past the line end.
  function automatic fetch_t pick_words(input line_t line, input woff_t woff);
    fetch_t res;
    res = '0;
    for (int i = 0; i < FETCH_WORDS; i++) begin
      if (int'(woff) + i < LINE_WORDS)
        res[i*WORD_W +: WORD_W] = line[(int'(woff) + i)*WORD_W +: WORD_W];
    end
    return res;
  endfunction

  // Tree walk: each node bit points toward the victim half.
  function automatic way_t plru_victim(input plru_t t);
    way_t w;
    int   node;
    w    = '0;
    node = 0;
    for (int l = 0; l < WAY_W; l++) begin
      w    = way_t'((int'(w) << 1) | int'(t[node]));
      node = 2*node + 1 + int'(t[node]);
    end
    return w;
  endfunction

  // Tree update: each node on the path is turned away from the used way.
  function automatic plru_t plru_touch(input plru_t t, input way_t w);
    plru_t r;
    int    node;
    logic  b;
    r    = t;
    node = 0;
    for (int l = 0; l < WAY_W; l++) begin
      b       = w[WAY_W-1-l];
      r[node] = ~b;
      node    = 2*node + 1 + int'(b);
    end
    return r;
  endfunction

  // Lowest invalid way first, tree victim otherwise.
  function automatic way_t pick_victim(input logic [WAYS-1:0] vld, input plru_t t);
    way_t w;
    logic found;
    w     = plru_victim(t);
    found = 1'b0;
    for (int i = 0; i < WAYS; i++) begin
      if (!vld[i] && !found) begin
        w     = way_t'(i);
        found = 1'b1;
      end
    end
    return w;
  endfunction

endpackage

// File: rtl/icache_tags.sv
module icache_tags
  import icache_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  idx_t lk_idx,
  input  tag_t lk_tag,
  output logic hit_any,
  output way_t hit_way,
  input  logic touch_en,
  input  idx_t fill_idx,
  input  tag_t fill_tag,
  input  logic fill_en,
  output way_t fill_way,
  input  logic flash,
  output logic any_valid
);

  logic [WAYS-1:0] vld_q [SETS];
  plru_t           plru_q [SETS];
  logic [WAYS-1:0] hit_vec;

  genvar g;
  generate
    for (g = 0; g < WAYS; g++) begin : g_way
      tag_t tag_mem [SETS];
      always_ff @(posedge clk) begin
        if (fill_en && fill_way == way_t'(g))
          tag_mem[fill_idx] <= fill_tag;
      end
      assign hit_vec[g] = vld_q[lk_idx][g] && (tag_mem[lk_idx] == lk_tag);
    end
  endgenerate

  always_comb begin
    hit_way = '0;
    for (int i = 0; i < WAYS; i++)
      if (hit_vec[i]) hit_way = way_t'(i);
  end
  assign hit_any  = |hit_vec;
  assign fill_way = pick_victim(vld_q[fill_idx], plru_q[fill_idx]);

  always_comb begin
    any_valid = 1'b0;
    for (int s = 0; s < SETS; s++)
      any_valid = any_valid | (|vld_q[s]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
    end else if (flash) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
    end else if (fill_en) begin
      vld_q[fill_idx][fill_way] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) plru_q[s] <= '0;
    end else if (fill_en) begin
      plru_q[fill_idx] <= plru_touch(plru_q[fill_idx], fill_way);
    end else if (touch_en) begin
      plru_q[lk_idx] <= plru_touch(plru_q[lk_idx], hit_way);
    end
  end

endmodule

// File: rtl/icache_data.sv
module icache_data
  import icache_pkg::*;
(
  input  logic  clk,
  input  logic  wr_en,
  input  idx_t  wr_idx,
  input  way_t  wr_way,
  input  line_t wr_line,
  input  idx_t  rd_idx,
  input  way_t  rd_way,
  output line_t rd_line
);

  line_t way_rd [WAYS];

  genvar g;
  generate
    for (g = 0; g < WAYS; g++) begin : g_way
      line_t mem_q [SETS];
      always_ff @(posedge clk) begin
        if (wr_en && wr_way == way_t'(g))
          mem_q[wr_idx] <= wr_line;
      end
      assign way_rd[g] = mem_q[rd_idx];
    end
  endgenerate

  assign rd_line = way_rd[rd_way];

endmodule

// File: rtl/icache_ctrl.sv
module icache_ctrl
  import icache_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_valid,
  input  laddr_t            fetch_line,
  input  woff_t             fetch_woff,
  input  logic              fetch_xlat_on,
  input  logic              fetch_page_coh,
  input  logic              ctl_disable,
  input  logic              ctl_lock,
  input  logic              ctl_fetch_coh,
  input  logic              ctl_flash_inv,
  input  logic              hit_any,
  input  line_t             hit_line,
  input  logic              refill_valid,
  input  line_t             refill_line,
  output logic              fetch_ready,
  output logic              resp_valid,
  output fetch_t            resp_words,
  output cnt_t              resp_count,
  output logic              miss_req_valid,
  output logic [ADDR_W-1:0] miss_req_addr,
  output logic              miss_req_global,
  output logic              miss_req_alloc,
  output logic              hit_fire,
  output logic              miss_fire,
  output logic              refill_fire,
  output logic              fill_en,
  output laddr_t            req_line
);

  typedef enum logic {ST_IDLE, ST_WAIT} st_t;

  st_t   st_q;
  woff_t req_woff_q;
  logic  lookup_fire;

  assign fetch_ready = (st_q == ST_IDLE);
  assign lookup_fire = fetch_valid & fetch_ready;
  assign hit_fire    = lookup_fire & hit_any & ~ctl_disable;
  assign miss_fire   = lookup_fire & ~hit_fire;
  assign refill_fire = (st_q == ST_WAIT) & refill_valid;
  assign fill_en     = refill_fire & miss_req_alloc & ~ctl_flash_inv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q            <= ST_IDLE;
      req_line        <= '0;
      req_woff_q      <= '0;
      resp_valid      <= 1'b0;
      resp_words      <= '0;
      resp_count      <= '0;
      miss_req_valid  <= 1'b0;
      miss_req_addr   <= '0;
      miss_req_global <= 1'b0;
      miss_req_alloc  <= 1'b0;
    end else begin
      resp_valid     <= hit_fire | refill_fire;
      miss_req_valid <= miss_fire;
      if (hit_fire) begin
        resp_words <= pick_words(hit_line, fetch_woff);
        resp_count <= fetch_count(fetch_woff);
      end
      if (miss_fire) begin
        st_q            <= ST_WAIT;
        req_line        <= fetch_line;
        req_woff_q      <= fetch_woff;
        miss_req_addr   <= {fetch_line, {OFF_W{1'b0}}};
        miss_req_global <= glob_attr(ctl_fetch_coh, fetch_xlat_on, fetch_page_coh);
        miss_req_alloc  <= ~ctl_disable & ~ctl_lock;
      end
      if (refill_fire) begin
        st_q       <= ST_IDLE;
        resp_words <= pick_words(refill_line, req_woff_q);
        resp_count <= fetch_count(req_woff_q);
      end
    end
  end

endmodule

// File: rtl/icache_top.sv
module icache_top
  import icache_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fetch_valid,
  input  logic [ADDR_W-1:0]   fetch_addr,
  input  logic                fetch_xlat_on,
  input  logic                fetch_page_coh,
  output logic                fetch_ready,
  output logic                resp_valid,
  output logic [FETCH_W-1:0]  resp_words,
  output logic [CNT_W-1:0]    resp_count,
  output logic                miss_req_valid,
  output logic [ADDR_W-1:0]   miss_req_addr,
  output logic                miss_req_global,
  output logic                miss_req_alloc,
  input  logic                refill_valid,
  input  logic [LINE_W-1:0]   refill_line,
  input  logic                ctl_disable,
  input  logic                ctl_flash_inv,
  input  logic                ctl_lock,
  input  logic                ctl_fetch_coh
);

  // Address fields of the incoming fetch.
  laddr_t fetch_line;
  woff_t  fetch_woff;
  idx_t   lk_idx;
  tag_t   lk_tag;
  logic   fetch_misaligned;

  assign fetch_line       = fetch_addr[ADDR_W-1:OFF_W];
  assign fetch_woff       = fetch_addr[OFF_W-1:WB_W];
  assign lk_idx           = fetch_line[IDX_W-1:0];
  assign lk_tag           = fetch_line[LADDR_W-1:IDX_W];
  assign fetch_misaligned = |fetch_addr[WB_W-1:0];

  // Named internal events.
  logic   hit_any;
  way_t   hit_way;
  way_t   fill_way;
  logic   any_valid;
  logic   hit_fire;
  logic   miss_fire;
  logic   refill_fire;
  logic   fill_en;
  laddr_t req_line;
  line_t  hit_line;

  icache_tags u_tags (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_idx    (lk_idx),
    .lk_tag    (lk_tag),
    .hit_any   (hit_any),
    .hit_way   (hit_way),
    .touch_en  (hit_fire),
    .fill_idx  (req_line[IDX_W-1:0]),
    .fill_tag  (req_line[LADDR_W-1:IDX_W]),
    .fill_en   (fill_en),
    .fill_way  (fill_way),
    .flash     (ctl_flash_inv),
    .any_valid (any_valid)
  );

  icache_data u_data (
    .clk     (clk),
    .wr_en   (fill_en),
    .wr_idx  (req_line[IDX_W-1:0]),
    .wr_way  (fill_way),
    .wr_line (refill_line),
    .rd_idx  (lk_idx),
    .rd_way  (hit_way),
    .rd_line (hit_line)
  );

  icache_ctrl u_ctrl (
    .clk             (clk),
    .rst_n           (rst_n),
    .fetch_valid     (fetch_valid),
    .fetch_line      (fetch_line),
    .fetch_woff      (fetch_woff),
    .fetch_xlat_on   (fetch_xlat_on),
    .fetch_page_coh  (fetch_page_coh),
    .ctl_disable     (ctl_disable),
    .ctl_lock        (ctl_lock),
    .ctl_fetch_coh   (ctl_fetch_coh),
    .ctl_flash_inv   (ctl_flash_inv),
    .hit_any         (hit_any),
    .hit_line        (hit_line),
    .refill_valid    (refill_valid),
    .refill_line     (refill_line),
    .fetch_ready     (fetch_ready),
    .resp_valid      (resp_valid),
    .resp_words      (resp_words),
    .resp_count      (resp_count),
    .miss_req_valid  (miss_req_valid),
    .miss_req_addr   (miss_req_addr),
    .miss_req_global (miss_req_global),
    .miss_req_alloc  (miss_req_alloc),
    .hit_fire        (hit_fire),
    .miss_fire       (miss_fire),
    .refill_fire     (refill_fire),
    .fill_en         (fill_en),
    .req_line        (req_line)
  );

endmodule

// File: rtl/icache_chk.sv
module icache_chk
  import icache_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             fetch_valid,
  input logic             fetch_misaligned,
  input logic             fetch_ready,
  input logic             resp_valid,
  input logic [CNT_W-1:0] resp_count,
  input logic             miss_req_valid,
  input logic             miss_req_global,
  input logic             miss_req_alloc,
  input logic             ctl_disable,
  input logic             ctl_flash_inv,
  input logic             ctl_lock,
  input logic             ctl_fetch_coh,
  input logic             hit_fire,
  input logic             miss_fire,
  input logic             refill_fire,
  input logic             any_valid
);

  // R2
  aligned_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |-> !fetch_misaligned);

  // R2
  hit_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_fire |=> resp_valid && !miss_req_valid);

  // R2
  resp_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> (resp_count != '0) && (int'(resp_count) <= FETCH_WORDS));

  // R3
  miss_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss_fire |=> miss_req_valid && !resp_valid);

  // R3
  refill_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refill_fire |=> resp_valid && fetch_ready && !miss_req_valid);

  // R6
  glob_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss_fire && !ctl_fetch_coh |=> !miss_req_global);

  // R7
  disable_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_disable |-> !hit_fire);

  // R8
  lock_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss_fire && (ctl_lock || ctl_disable) |=> !miss_req_alloc);

  // R9
  flash_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_flash_inv |=> !any_valid);

  // R10
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss_req_valid |-> !fetch_ready);

endmodule

bind icache_top icache_chk u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .fetch_valid      (fetch_valid),
  .fetch_misaligned (fetch_misaligned),
  .fetch_ready      (fetch_ready),
  .resp_valid       (resp_valid),
  .resp_count       (resp_count),
  .miss_req_valid   (miss_req_valid),
  .miss_req_global  (miss_req_global),
  .miss_req_alloc   (miss_req_alloc),
  .ctl_disable      (ctl_disable),
  .ctl_flash_inv    (ctl_flash_inv),
  .ctl_lock         (ctl_lock),
  .ctl_fetch_coh    (ctl_fetch_coh),
  .hit_fire         (hit_fire),
  .miss_fire        (miss_fire),
  .refill_fire      (refill_fire),
  .any_valid        (any_valid)
);

// File: tb/icache_top_tb.sv
`timescale 1ns/1ps
module icache_top_tb;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         fetch_valid = 1'b0;
  logic [31:0]  fetch_addr = '0;
  logic         fetch_xlat_on = 1'b0;
  logic         fetch_page_coh = 1'b0;
  logic         fetch_ready;
  logic         resp_valid;
  logic [127:0] resp_words;
  logic [2:0]   resp_count;
  logic         miss_req_valid;
  logic [31:0]  miss_req_addr;
  logic         miss_req_global;
  logic         miss_req_alloc;
  logic         refill_valid = 1'b0;
  logic [255:0] refill_line = '0;
  logic         ctl_disable = 1'b0;
  logic         ctl_flash_inv = 1'b0;
  logic         ctl_lock = 1'b0;
  logic         ctl_fetch_coh = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  icache_top u_dut (.*);

  // Reference model: 256 sets of four ways.
  bit          mv [256][4];
  logic [18:0] mt [256][4];
  logic [2:0]  mp [256];

  function automatic logic [31:0] mem_word(input logic [31:0] line, input int k);
    return (line ^ 32'h5A5A_0000) + 32'h0101_0001 * k;
  endfunction

  function automatic logic [255:0] mem_line(input logic [31:0] a);
    logic [255:0] r;
    for (int k = 0; k < 8; k++) r[32*k +: 32] = mem_word({a[31:5], 5'b0}, k);
    return r;
  endfunction

  function automatic logic [127:0] exp_words(input logic [31:0] a);
    logic [127:0] r;
    int w;
    r = '0;
    w = int'(a[4:2]);
    for (int i = 0; i < 4; i++)
      if (w + i < 8) r[32*i +: 32] = mem_word({a[31:5], 5'b0}, w + i);
    return r;
  endfunction

  function automatic int exp_count(input logic [31:0] a);
    int left;
    left = 8 - int'(a[4:2]);
    return (left < 4) ? left : 4;
  endfunction

  function automatic bit exp_glob(input bit mode, input bit xl, input bit pm);
    if (!mode) return 1'b0;
    if (!xl) return 1'b1;
    return pm;
  endfunction

  function automatic int tree_victim(input logic [2:0] t);
    if (t[0] == 1'b0) return t[1] ? 1 : 0;
    return t[2] ? 3 : 2;
  endfunction

  task automatic tree_touch(input int s, input int w);
    case (w)
      0: begin mp[s][0] = 1'b1; mp[s][1] = 1'b1; end
      1: begin mp[s][0] = 1'b1; mp[s][1] = 1'b0; end
      2: begin mp[s][0] = 1'b0; mp[s][2] = 1'b1; end
      default: begin mp[s][0] = 1'b0; mp[s][2] = 1'b0; end
    endcase
  endtask

  task automatic model_lookup(input logic [31:0] a, output bit h, output int w);
    int s;
    s = int'(a[12:5]);
    h = 0;
    w = 0;
    for (int i = 0; i < 4; i++)
      if (mv[s][i] && mt[s][i] == a[31:13]) begin h = 1; w = i; end
  endtask

  task automatic model_fill(input logic [31:0] a);
    int s;
    int w;
    s = int'(a[12:5]);
    w = -1;
    for (int i = 3; i >= 0; i--) if (!mv[s][i]) w = i;
    if (w < 0) w = tree_victim(mp[s]);
    mv[s][w] = 1;
    mt[s][w] = a[31:13];
    tree_touch(s, w);
  endtask

  task automatic model_flash();
    for (int s = 0; s < 256; s++)
      for (int i = 0; i < 4; i++) mv[s][i] = 0;
  endtask

  task automatic chk(input string rq, input string what, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  // exp_hit: 0 miss, 1 hit, 2 taken from the model.
  task automatic fetch_one(input logic [31:0] a, input bit xl, input bit pm,
                           input int exp_hit, input bit flash_at_fill, input string rq);
    bit mh;
    int mw;
    bit eh;
    bit ealloc;
    int dly;
    model_lookup(a, mh, mw);
    if (ctl_disable) mh = 0;
    eh = (exp_hit == 2) ? mh : (exp_hit == 1);
    ealloc = !ctl_disable && !ctl_lock;
    while (!fetch_ready) @(negedge clk);
    fetch_valid = 1'b1;
    fetch_addr = a;
    fetch_xlat_on = xl;
    fetch_page_coh = pm;
    @(negedge clk);
    fetch_valid = 1'b0;
    chk(rq, "hit path resp_valid", 128'(resp_valid), 128'(eh));
    chk(rq, "hit path miss_req_valid", 128'(miss_req_valid), 128'(!eh));
    if (eh) begin
      chk(rq, "hit words", resp_words, exp_words(a));
      chk(rq, "hit count", 128'(resp_count), 128'(exp_count(a)));
      if (mh) tree_touch(int'(a[12:5]), mw);
    end else begin
      chk(rq, "miss addr", 128'(miss_req_addr), 128'({a[31:5], 5'b0}));
      chk("R6", "miss global", 128'(miss_req_global), 128'(exp_glob(ctl_fetch_coh, xl, pm)));
      chk(rq, "miss alloc", 128'(miss_req_alloc), 128'(ealloc));
      chk("R10", "ready during miss", 128'(fetch_ready), 128'(0));
      dly = $urandom_range(0, 3);
      repeat (dly) begin
        @(negedge clk);
        chk("R10", "stalled ready/resp", 128'({fetch_ready, resp_valid}), 128'(0));
      end
      refill_valid = 1'b1;
      refill_line = mem_line(a);
      ctl_flash_inv = flash_at_fill;
      @(negedge clk);
      refill_valid = 1'b0;
      ctl_flash_inv = 1'b0;
      chk("R3", "refill resp_valid", 128'(resp_valid), 128'(1));
      chk("R3", "refill words", resp_words, exp_words(a));
      chk("R3", "refill count", 128'(resp_count), 128'(exp_count(a)));
      chk("R10", "ready after refill", 128'(fetch_ready), 128'(1));
      if (flash_at_fill) model_flash();
      else if (ealloc) model_fill(a);
    end
  endtask

  task automatic flash_pulse();
    ctl_flash_inv = 1'b1;
    @(negedge clk);
    ctl_flash_inv = 1'b0;
    model_flash();
  endtask

  function automatic logic [31:0] mk(input int tag, input int set, input int w);
    return {19'(tag), 8'(set), 3'(w), 2'b00};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int s = 0; s < 256; s++) begin
      mp[s] = 3'b000;
      for (int i = 0; i < 4; i++) begin mv[s][i] = 0; mt[s][i] = '0; end
    end
    repeat (3) @(negedge clk);
    chk("R1", "reset resp_valid", 128'(resp_valid), 128'(0));
    chk("R1", "reset miss_req_valid", 128'(miss_req_valid), 128'(0));
    chk("R1", "reset fetch_ready", 128'(fetch_ready), 128'(1));
    rst_n = 1'b1;
    @(negedge clk);

    // R1 first fetch misses, R2 refetch hits with several offsets
    fetch_one(mk(9, 1, 0), 0, 0, 0, 0, "R1");
    fetch_one(mk(9, 1, 0), 0, 0, 1, 0, "R2");
    fetch_one(mk(9, 1, 4), 0, 0, 1, 0, "R2");
    fetch_one(mk(9, 1, 5), 0, 0, 1, 0, "R2");
    fetch_one(mk(9, 1, 7), 0, 0, 1, 0, "R2");
    fetch_one(mk(9, 2, 6), 0, 0, 0, 0, "R4");

    // R4/R5 five tags into set 7
    for (int t = 1; t <= 5; t++) fetch_one(mk(t, 7, 0), 0, 0, 0, 0, "R4");
    fetch_one(mk(9, 1, 2), 0, 0, 1, 0, "R4");
    fetch_one(mk(2, 7, 1), 0, 0, 1, 0, "R5");
    fetch_one(mk(1, 7, 3), 0, 0, 0, 0, "R5");
    fetch_one(mk(4, 7, 0), 0, 0, 1, 0, "R5");
    fetch_one(mk(3, 7, 0), 0, 0, 0, 0, "R5");

    // R6 attribute combinations
    ctl_fetch_coh = 1'b0;
    fetch_one(mk(40, 3, 0), 1, 1, 0, 0, "R6");
    ctl_fetch_coh = 1'b1;
    fetch_one(mk(41, 3, 0), 1, 0, 0, 0, "R6");
    fetch_one(mk(42, 3, 0), 1, 1, 0, 0, "R6");
    fetch_one(mk(43, 3, 0), 0, 0, 0, 0, "R6");
    ctl_fetch_coh = 1'b0;

    // R7 disable leaves contents alone
    ctl_disable = 1'b1;
    fetch_one(mk(9, 1, 0), 0, 0, 0, 0, "R7");
    fetch_one(mk(60, 1, 0), 0, 0, 0, 0, "R7");
    ctl_disable = 1'b0;
    fetch_one(mk(9, 1, 0), 0, 0, 1, 0, "R7");
    fetch_one(mk(60, 1, 0), 0, 0, 0, 0, "R7");

    // R8 lock: hits served, misses not stored
    ctl_lock = 1'b1;
    fetch_one(mk(4, 7, 2), 0, 0, 1, 0, "R8");
    fetch_one(mk(70, 7, 0), 0, 0, 0, 0, "R8");
    fetch_one(mk(70, 7, 0), 0, 0, 0, 0, "R8");
    fetch_one(mk(4, 7, 0), 0, 0, 1, 0, "R8");
    ctl_lock = 1'b0;

    // R9 flash invalidate, alone and on a refill beat
    flash_pulse();
    fetch_one(mk(9, 1, 0), 0, 0, 0, 0, "R9");
    fetch_one(mk(80, 5, 0), 0, 0, 0, 1, "R9");
    fetch_one(mk(80, 5, 0), 0, 0, 0, 0, "R9");
    fetch_one(mk(9, 1, 0), 0, 0, 0, 0, "R9");

    // Random mix against the model
    for (int n = 0; n < 600; n++) begin
      ctl_fetch_coh = 1'($urandom_range(0, 1));
      ctl_lock      = ($urandom_range(0, 9) == 0);
      ctl_disable   = ($urandom_range(0, 14) == 0);
      if ($urandom_range(0, 39) == 0) flash_pulse();
      fetch_one(mk(100 + $urandom_range(0, 5), 3 + 37 * $urandom_range(0, 2), $urandom_range(0, 7)),
                1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 2,
                ($urandom_range(0, 24) == 0), "R5");
    end
    finish_run();
  end

endmodule